// File: doc/BRIEF.md
# Rotating Word Seven-Segment Display

This block shows a short word, up to five characters long, across a row of seven-segment digits. It can turn the word around the row in a circle. Each character arrives as a 3-bit code. A 3-bit rotation select picks how far the word is turned. Every digit has its own selector, built as a tree of 2-to-1 multiplexers. Each selector receives the character codes in an order shifted by that digit's position. The chosen code then goes to a glyph decoder, which produces one active-low 7-bit segment pattern per digit.

The parameter `DIGITS` chooses one of two variants:

- **Five digits:** the word fills every position. Each selector is a 5-way selector, and selects above four hold at the last rotation.
- **Eight digits:** the word sits in an eight-slot ring together with three blank slots, and each selector is an 8-way selector. The blank slots come from a constant inside the block, so they travel with the word as it rotates.

The block has no clock and no stored state. There are no state names or transitions to list. It is pure combinational selection and decoding.

Top module: `rotword_display`

## Requirements
- R1: Character codes decode to active-low segments, where a segment lights when its bit is 0. Bit i of a digit's slice drives segment i. Segments 0 to 6 are top, upper right, lower right, bottom, lower left, upper left and middle. Code 000 (H) lights 1,2,4,5,6. Code 001 (E) lights 0,3,4,5,6. Code 010 (L) lights 3,4,5. Code 011 (O) lights 0 to 5.
- R2: Every code from 100 to 111 decodes to blank, with all seven segment bits at 1.
- R3: With DIGITS=5 and rotation select k from 0 to 4, digit d shows character (d+k) mod 5. Digit 0 is the leftmost digit. Character j is `word_codes[3j+2:3j]`.
- R4: With DIGITS=5, selects 5, 6 and 7 give exactly the same outputs as select 4.
- R5: With DIGITS=8, digit d under select k shows ring slot (d+k) mod 8. Slots 0, 1 and 2 are blank, and slot 3+j holds character j.
- R6: With DIGITS=8, select 0 places the word on digits 3 to 7, right-aligned. Select 3 places it on digits 0 to 4, left-aligned. Select 4 wraps the first character onto digit 7.
- R7: With DIGITS=8, a digit that falls on a blank ring slot is all ones, whatever the character codes hold.
- R8: The outputs follow the inputs with no clock and no stored state. A change of inputs shows on the outputs before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rot_sel | input | 3 | Rotation amount |
| word_codes | input | 15 | Five 3-bit character codes; character j at bits 3j+2..3j |
| digit_segs | output | DIGITS*7 | Active-low segments; digit d at bits 7d+6..7d, bit 7d+i is segment i |

## Verification
The embedded checks run on every evaluation and cover three things:
- a blank code always reaches its digit as a fully dark pattern;
- each lettered glyph lights its expected number of segments;
- the code chosen by each digit's selector matches the shifted position, including the clamp above select 4 and the blank slots of the eight-digit ring.

The exact segment shapes, and the absence of any stored state, can only be shown by the bench. It sweeps every select over a few dozen words in both variants, including HELLO and words made only of blank codes, and compares each digit against an independent model.

// File: rtl/rotdisp_pkg.sv
package rotdisp_pkg;
    localparam int CODE_W = 3;
    localparam int SEG_W  = 7;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    localparam code_t GLYPH_H     = 3'b000;
    localparam code_t GLYPH_E     = 3'b001;
    localparam code_t GLYPH_L     = 3'b010;
    localparam code_t GLYPH_O     = 3'b011;
    localparam code_t GLYPH_BLANK = 3'b111;
    localparam seg_t  SEG_DARK    = 7'b111_1111;
endpackage

// File: rtl/rotdisp_mux2.sv
module rotdisp_mux2 #(
    parameter int WIDTH = 3
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] in_lo,
    input  logic [WIDTH-1:0] in_hi,
    output logic [WIDTH-1:0] out_m
);
    localparam logic [WIDTH-1:0] ONES = '1;

    // Sum-of-products form applied bit by bit across the whole width.
    logic [WIDTH-1:0] sel_vec;

    always_comb begin
        sel_vec = sel ? ONES : '0;
        out_m   = (~sel_vec & in_lo) | (sel_vec & in_hi);
    end
endmodule

// File: rtl/rotdisp_mux5.sv
module rotdisp_mux5 #(
    parameter int WIDTH = 3
) (
    input  logic [2:0]         sel,
    input  logic [5*WIDTH-1:0] taps,
    output logic [WIDTH-1:0]   out_m
);
    logic [WIDTH-1:0] pair_a, pair_b, quad;

    // First level: select bit 0 chooses within each pair of taps.
    rotdisp_mux2 #(.WIDTH(WIDTH)) u_pair_a (
        .sel   (sel[0]),
        .in_lo (taps[0*WIDTH +: WIDTH]),
        .in_hi (taps[1*WIDTH +: WIDTH]),
        .out_m (pair_a)
    );

    rotdisp_mux2 #(.WIDTH(WIDTH)) u_pair_b (
        .sel   (sel[0]),
        .in_lo (taps[2*WIDTH +: WIDTH]),
        .in_hi (taps[3*WIDTH +: WIDTH]),
        .out_m (pair_b)
    );

    // Second level: select bit 1 chooses between the two pairs.
    rotdisp_mux2 #(.WIDTH(WIDTH)) u_quad (
        .sel   (sel[1]),
        .in_lo (pair_a),
        .in_hi (pair_b),
        .out_m (quad)
    );

    // Top bit set picks the last tap, so selects 4 to 7 all land on it.
    rotdisp_mux2 #(.WIDTH(WIDTH)) u_last (
        .sel   (sel[2]),
        .in_lo (quad),
        .in_hi (taps[4*WIDTH +: WIDTH]),
        .out_m (out_m)
    );
endmodule

// File: rtl/rotdisp_mux8.sv
module rotdisp_mux8 #(
    parameter int WIDTH = 3
) (
    input  logic [2:0]         sel,
    input  logic [8*WIDTH-1:0] taps,
    output logic [WIDTH-1:0]   out_m
);
    logic [4*WIDTH-1:0] lvl1;
    logic [2*WIDTH-1:0] lvl2;

    // Seven 2-to-1 stages arranged in three levels.
    for (genvar p = 0; p < 4; p++) begin : g_lvl1
        rotdisp_mux2 #(.WIDTH(WIDTH)) u_stage (
            .sel   (sel[0]),
            .in_lo (taps[(2*p)*WIDTH   +: WIDTH]),
            .in_hi (taps[(2*p+1)*WIDTH +: WIDTH]),
            .out_m (lvl1[p*WIDTH +: WIDTH])
        );
    end

    for (genvar p = 0; p < 2; p++) begin : g_lvl2
        rotdisp_mux2 #(.WIDTH(WIDTH)) u_stage (
            .sel   (sel[1]),
            .in_lo (lvl1[(2*p)*WIDTH   +: WIDTH]),
            .in_hi (lvl1[(2*p+1)*WIDTH +: WIDTH]),
            .out_m (lvl2[p*WIDTH +: WIDTH])
        );
    end

    rotdisp_mux2 #(.WIDTH(WIDTH)) u_root (
        .sel   (sel[2]),
        .in_lo (lvl2[0 +: WIDTH]),
        .in_hi (lvl2[WIDTH +: WIDTH]),
        .out_m (out_m)
    );
endmodule

// File: rtl/rotdisp_glyph.sv
module rotdisp_glyph
    import rotdisp_pkg::*;
(
    input  code_t code,
    output seg_t  segs
);
    logic c2, c1, c0;

    // One Boolean expression per segment; a 1 keeps the segment dark.
    always_comb begin
        {c2, c1, c0} = code;
        segs[0] = c2 | ~c0;
        segs[1] = c2 | (c1 ^ c0);
        segs[2] = c2 | (c1 ^ c0);
        segs[3] = c2 | (~c1 & ~c0);
        segs[4] = c2;
        segs[5] = c2;
        segs[6] = c2 | c1;
    end
endmodule

// File: rtl/rotword_display.sv
module rotword_display
    import rotdisp_pkg::*;
#(
    parameter int DIGITS = 5,
    parameter int CHARS  = 5
) (
    input  logic [CODE_W-1:0]       rot_sel,
    input  logic [CHARS*CODE_W-1:0] word_codes,
    output logic [DIGITS*SEG_W-1:0] digit_segs
);
    localparam int PAD       = DIGITS - CHARS;
    localparam bit WIDE_RING = (DIGITS == 8);

    code_t ring [DIGITS];
    code_t pick [DIGITS];

    // Ring slots: constant blanks first, then the characters in order.
    for (genvar i = 0; i < DIGITS; i++) begin : g_ring
        if (i < PAD) begin : g_pad
            assign ring[i] = GLYPH_BLANK;
        end else begin : g_char
            assign ring[i] = word_codes[(i-PAD)*CODE_W +: CODE_W];
        end
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [DIGITS*CODE_W-1:0] taps;
        seg_t                     segs_d;

        // Tap j of digit d is ring slot (d + j) mod DIGITS.
        for (genvar j = 0; j < DIGITS; j++) begin : g_tap
            assign taps[j*CODE_W +: CODE_W] = ring[(d + j) % DIGITS];
        end

        if (WIDE_RING) begin : g_sel8
            rotdisp_mux8 #(.WIDTH(CODE_W)) u_sel (
                .sel   (rot_sel),
                .taps  (taps),
                .out_m (pick[d])
            );
        end else begin : g_sel5
            rotdisp_mux5 #(.WIDTH(CODE_W)) u_sel (
                .sel   (rot_sel),
                .taps  (taps),
                .out_m (pick[d])
            );
        end

        rotdisp_glyph u_glyph (
            .code (pick[d]),
            .segs (segs_d)
        );

        assign digit_segs[d*SEG_W +: SEG_W] = segs_d;

        always_comb begin
            // R2: a blank code reaching the decoder leaves the digit dark.
            a_r2_blank_dark: assert (!pick[d][2] || segs_d == SEG_DARK)
                else $error("blank code lit digit %0d", d);
            // R1: each lettered glyph lights its own number of segments.
            a_r1_lit_count: assert (pick[d][2] ||
                    (pick[d] == GLYPH_H && $countones(~segs_d) == 5) ||
                    (pick[d] == GLYPH_E && $countones(~segs_d) == 5) ||
                    (pick[d] == GLYPH_L && $countones(~segs_d) == 3) ||
                    (pick[d] == GLYPH_O && $countones(~segs_d) == 6))
                else $error("wrong lit count on digit %0d", d);
            if (WIDE_RING) begin
                // R7: digits on the padding slots see the constant blank.
                a_r7_pad_blank: assert (((d + int'(rot_sel)) % DIGITS) >= PAD
                        || pick[d] == GLYPH_BLANK)
                    else $error("padding slot not blank on digit %0d", d);
                // R5: other digits see the character for their ring slot.
                a_r5_ring_pick: assert (((d + int'(rot_sel)) % DIGITS) < PAD
                        || pick[d] == word_codes[(((d + int'(rot_sel)) % DIGITS) - PAD)*CODE_W +: CODE_W])
                    else $error("ring slot mismatch on digit %0d", d);
            end else begin
                // R4: selects above four hold at the last rotation.
                a_r4_clamp: assert (rot_sel < 3'd4 ||
                        pick[d] == word_codes[((d + 4) % DIGITS)*CODE_W +: CODE_W])
                    else $error("clamp mismatch on digit %0d", d);
                // R3: selects 0 to 3 rotate by the select value.
                a_r3_rotate: assert (rot_sel >= 3'd4 ||
                        pick[d] == word_codes[((d + int'(rot_sel)) % DIGITS)*CODE_W +: CODE_W])
                    else $error("rotation mismatch on digit %0d", d);
            end
        end
    end
endmodule

// File: tb/rotword_display_bench.sv
module rotword_display_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [2:0]  sel;
    logic [14:0] word;
    logic [34:0] segs5;
    logic [55:0] segs8;
    int          total = 0;
    int          fails = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotword_display #(.DIGITS(5)) u_rotword_display (
        .rot_sel(sel), .word_codes(word), .digit_segs(segs5));

    rotword_display #(.DIGITS(8)) u_rotword_display_wide (
        .rot_sel(sel), .word_codes(word), .digit_segs(segs8));

    function automatic logic [6:0] glyph(input logic [2:0] c);
        case (c)
            3'd0:    return 7'b0001001; // H
            3'd1:    return 7'b0000110; // E
            3'd2:    return 7'b1000111; // L
            3'd3:    return 7'b1000000; // O
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic logic [2:0] char_at(input logic [14:0] w, input int j);
        return w[3*j +: 3];
    endfunction

    function automatic logic [2:0] exp5(input logic [14:0] w, input int d, input int k);
        int kk = (k > 4) ? 4 : k;
        return char_at(w, (d + kk) % 5);
    endfunction

    function automatic logic [2:0] exp8(input logic [14:0] w, input int d, input int k);
        int p = (d + k) % 8;
        return (p < 3) ? 3'b111 : char_at(w, p - 3);
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] pack(input logic [2:0] a, input logic [2:0] b,
                                         input logic [2:0] c, input logic [2:0] d,
                                         input logic [2:0] e);
        return {e, d, c, b, a};
    endfunction

    task automatic sweep_word(input logic [14:0] w);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            word = w;
            sel  = 3'(k);
            @(negedge clk);
            for (int d = 0; d < 5; d++) begin
                logic [2:0] c = exp5(w, d, k);
                check(k > 4 ? "R4" : (c[2] ? "R2/R3" : "R1/R3"),
                      segs5[7*d +: 7], glyph(c));
            end
            for (int d = 0; d < 8; d++) begin
                int p = (d + k) % 8;
                check(p < 3 ? "R7" : "R5", segs8[7*d +: 7], glyph(exp8(w, d, k)));
            end
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                total++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        logic [14:0] hello;
        logic [14:0] w;
        hello = pack(3'd0, 3'd1, 3'd2, 3'd2, 3'd3);
        sel  = 3'd0;
        word = hello;
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R1: each glyph shape at select 0 on the five-digit variant.
        check("R1 H", segs5[0 +: 7],  7'b0001001);
        check("R1 E", segs5[7 +: 7],  7'b0000110);
        check("R1 L", segs5[14 +: 7], 7'b1000111);
        check("R1 O", segs5[28 +: 7], 7'b1000000);

        // R6: right-aligned at select 0, left-aligned at select 3, wrap at 4.
        check("R6 sel0 d3", segs8[21 +: 7], 7'b0001001);
        check("R6 sel0 d0", segs8[0 +: 7],  7'b1111111);
        check("R6 sel0 d7", segs8[49 +: 7], 7'b1000000);
        @(posedge clk); sel = 3'd3; @(negedge clk);
        check("R6 sel3 d0", segs8[0 +: 7],  7'b0001001);
        check("R6 sel3 d4", segs8[28 +: 7], 7'b1000000);
        check("R6 sel3 d7", segs8[49 +: 7], 7'b1111111);
        @(posedge clk); sel = 3'd4; @(negedge clk);
        check("R6 sel4 d7", segs8[49 +: 7], 7'b0001001);
        check("R6 sel4 d0", segs8[0 +: 7],  7'b0000110);

        // R3: HELLO at select 2 reads L L O H E.
        @(posedge clk); sel = 3'd2; @(negedge clk);
        check("R3 sel2 d0", segs5[0 +: 7],  7'b1000111);
        check("R3 sel2 d3", segs5[21 +: 7], 7'b0001001);

        // R8: change inputs between edges, outputs follow before the next edge.
        #1 word = pack(3'd3, 3'd3, 3'd3, 3'd3, 3'd3);
        #1 check("R8 no clock", segs5[0 +: 7], 7'b1000000);

        // R2: each blank code alone.
        for (int b = 4; b < 8; b++) begin
            @(posedge clk);
            sel  = 3'd0;
            word = pack(3'(b), 3'(b), 3'(b), 3'(b), 3'(b));
            @(negedge clk);
            check("R2 blank", segs5[0 +: 7], 7'b1111111);
        end

        // Full sweeps across many words, both variants, every select.
        sweep_word(hello);
        sweep_word(pack(3'd4, 3'd5, 3'd6, 3'd7, 3'd4));
        sweep_word(pack(3'd3, 3'd2, 3'd1, 3'd0, 3'd7));
        for (int n = 0; n < 40; n++) begin
            for (int j = 0; j < 5; j++)
                w[3*j +: 3] = 3'((n * 7 + j * 3 + (n >> 2) * j) % 8);
            sweep_word(w);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule